// File: doc/BRIEF.md
# Macro Sequencer with Delay-Slot Branching

This block is the control unit of a small macro processor. When a macro call begins, it clears the eight general-purpose registers and its own flow state. It then fetches 32-bit instruction words one at a time from a synchronous instruction memory, starting at the entry address given with the start strobe. Each word that is not a branch goes to the execute datapath. Branch words are resolved inside the sequencer and are never sent on.

A branch reads one register through the zero-test port and decides whether to jump. It then either jumps at once (annulled) or first runs the word that follows it (delay slot). Any word can also carry an exit flag. The word after an exit word still runs, and then the sequencer reports completion with a one-cycle done strobe and returns to idle. Every fetch takes two cycles: one to present the address and one to receive the word.

Top module: `msq_seq`

## Requirements
- R1: After reset, `busy`, `done`, `gpr_clr`, `imem_rd_en` and `issue_valid` are low. While idle, no fetch and no issue occurs.
- R2: A `start` pulse seen while idle produces a one-cycle `gpr_clr` pulse in the next cycle. In that same cycle the first fetch is presented at `entry_addr`, so a register left nonzero by an earlier macro reads as zero.
- R3: A `start` pulse that arrives while the sequencer is busy is ignored. The running macro is not disturbed and no second run follows it.
- R4: Every word is fetched with a one-cycle `imem_rd_en` pulse. Its data is taken one cycle later. Non-branch words appear on `issue_insn` with `issue_valid` in program order, one per two cycles.
- R5: A word whose bits [2:0] equal 7 is a branch. It tests the register chosen by bits [13:11]. Bit 4 clear means the branch is taken when that value is zero; bit 4 set means it is taken when the value is nonzero. The target is the branch's own address plus the signed 18-bit value in bits [31:14], wrapping at the memory depth.
- R6: A taken branch with bit 5 set fetches the target next, with no delay slot.
- R7: A taken branch with bit 5 clear runs the word at its address plus one, and then continues at the target.
- R8: A branch that is not taken continues at its address plus one, and no slot handling applies.
- R9: A branch that sits in a delay slot is neither issued nor allowed to redirect the flow.
- R10: A word with bit 7 set is an exit word, even when it is also a branch; in that case its branch part is dropped. The following word runs (and is issued unless it is a branch). In the cycle that follows, `done` pulses for one cycle and `busy` falls.
- R11: An exit word that sits in a delay slot ends the macro right after itself.
- R12: Instruction addresses wrap from the last memory location to location zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a macro call (taken only when idle) |
| entry_addr | input | PC_W | First instruction address of the call |
| imem_rd_en | output | 1 | Instruction memory read enable |
| imem_addr | output | PC_W | Instruction memory read address |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the read |
| test_sel | output | 3 | Register index to test for a branch |
| test_value | input | 32 | Value of the register chosen by `test_sel` |
| gpr_clr | output | 1 | One-cycle pulse clearing all general-purpose registers |
| issue_valid | output | 1 | `issue_insn` holds a word for the datapath |
| issue_insn | output | 32 | Non-branch instruction word sent to the datapath |
| busy | output | 1 | A macro call is in progress |
| done | output | 1 | One-cycle pulse at the end of a call |

## Verification
The bench goes after these cases:
- **Annul bit in both settings.** A design that swapped the meaning of the annul bit would issue words that lie between a branch and its target, or drop the slot word. Either mistake shows up in the issue stream.
- **A branch inside a delay slot.** Its target points at a marker word that must not come next. A design that honoured it would issue that marker out of order.
- **Exit placement.** Exit is tested on an ordinary word, on a branch, and inside a delay slot. A sequencer that stopped at the exit word itself would end with one word missing and would raise done two cycles early. One that ignored an exit in a slot would run past the end.
- **Remaining corners.** The bench also covers a backward branch, a run that wraps past the top address, and a start pulse while busy. A design that reloaded the PC on that pulse would send the wrong words.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int INSN_W   = 32;
  localparam int OP_LSB   = 0;
  localparam int OP_W     = 3;
  localparam int COND_BIT = 4;
  localparam int ANNUL_BIT = 5;
  localparam int EXIT_BIT = 7;
  localparam int SRCA_LSB = 11;
  localparam int SEL_W    = 3;
  localparam int OFF_LSB  = 14;
  localparam int OFF_W    = 18;
  localparam logic [OP_W-1:0] OP_BRANCH = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/msq_decode.sv
module msq_decode
  import msq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSN_W-1:0]       insn,
  input  logic [DATA_W-1:0]       test_value,
  output logic                    is_branch,
  output logic                    is_exit,
  output logic                    annul,
  output logic                    taken,
  output logic [SEL_W-1:0]        src_a,
  output logic signed [OFF_W-1:0] offset
);
  logic on_nonzero;
  logic val_zero;
  logic unused_fields;

  assign unused_fields = ^{insn[10:8], insn[6], insn[3]};

  always_comb begin
    is_branch  = (insn[OP_LSB +: OP_W] == OP_BRANCH);
    is_exit    = insn[EXIT_BIT];
    annul      = insn[ANNUL_BIT];
    on_nonzero = insn[COND_BIT];
    src_a      = insn[SRCA_LSB +: SEL_W];
    offset     = $signed(insn[OFF_LSB +: OFF_W]);
    val_zero   = (test_value == '0);
    taken      = is_branch & (on_nonzero ? ~val_zero : val_zero);
  end
endmodule

// File: rtl/msq_next_pc.sv
module msq_next_pc
  import msq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                    in_slot,
  input  logic                    exit_pend,
  input  logic [PC_W-1:0]         pc,
  input  logic [PC_W-1:0]         slot_tgt,
  input  logic                    is_branch,
  input  logic                    is_exit,
  input  logic                    annul,
  input  logic                    taken,
  input  logic signed [OFF_W-1:0] offset,
  output logic [PC_W-1:0]         nxt_pc,
  output logic [PC_W-1:0]         nxt_tgt,
  output logic                    nxt_slot,
  output logic                    nxt_exit_pend,
  output logic                    finish,
  output logic                    issue
);
  logic [PC_W-1:0] off_pc;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] br_tgt;

  generate
    if (PC_W < OFF_W) begin : g_trunc
      logic [OFF_W-PC_W-1:0] unused_hi;
      assign unused_hi = offset[OFF_W-1:PC_W];
      assign off_pc    = offset[PC_W-1:0];
    end else begin : g_sext
      assign off_pc = PC_W'(offset);
    end
  endgenerate

  assign seq_pc = pc + PC_W'(1);
  assign br_tgt = pc + off_pc;

  always_comb begin
    issue         = ~is_branch;
    finish        = 1'b0;
    nxt_pc        = seq_pc;
    nxt_tgt       = slot_tgt;
    nxt_slot      = 1'b0;
    nxt_exit_pend = 1'b0;
    if (in_slot) begin
      finish = exit_pend | is_exit;
      nxt_pc = slot_tgt;
    end else if (is_exit) begin
      nxt_slot      = 1'b1;
      nxt_exit_pend = 1'b1;
    end else if (taken) begin
      if (annul) begin
        nxt_pc = br_tgt;
      end else begin
        nxt_slot = 1'b1;
        nxt_tgt  = br_tgt;
      end
    end
  end
endmodule

// File: rtl/msq_seq.sv
module msq_seq
  import msq_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PC_W-1:0]   entry_addr,
  output logic              imem_rd_en,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [SEL_W-1:0]  test_sel,
  input  logic [DATA_W-1:0] test_value,
  output logic              gpr_clr,
  output logic              issue_valid,
  output logic [INSN_W-1:0] issue_insn,
  output logic              busy,
  output logic              done
);
  seq_state_t state;
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] slot_tgt;
  logic            in_slot;
  logic            exit_pend;

  logic                    d_branch, d_exit, d_annul, d_taken;
  logic signed [OFF_W-1:0] d_offset;
  logic [PC_W-1:0]         n_pc, n_tgt;
  logic                    n_slot, n_exit_pend, n_finish, n_issue;

  msq_decode #(.DATA_W(DATA_W)) u_dec (
    .insn       (imem_rdata),
    .test_value (test_value),
    .is_branch  (d_branch),
    .is_exit    (d_exit),
    .annul      (d_annul),
    .taken      (d_taken),
    .src_a      (test_sel),
    .offset     (d_offset)
  );

  msq_next_pc #(.PC_W(PC_W)) u_npc (
    .in_slot       (in_slot),
    .exit_pend     (exit_pend),
    .pc            (pc),
    .slot_tgt      (slot_tgt),
    .is_branch     (d_branch),
    .is_exit       (d_exit),
    .annul         (d_annul),
    .taken         (d_taken),
    .offset        (d_offset),
    .nxt_pc        (n_pc),
    .nxt_tgt       (n_tgt),
    .nxt_slot      (n_slot),
    .nxt_exit_pend (n_exit_pend),
    .finish        (n_finish),
    .issue         (n_issue)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pc          <= '0;
      slot_tgt    <= '0;
      in_slot     <= 1'b0;
      exit_pend   <= 1'b0;
      imem_rd_en  <= 1'b0;
      imem_addr   <= '0;
      gpr_clr     <= 1'b0;
      issue_valid <= 1'b0;
      issue_insn  <= '0;
      done        <= 1'b0;
    end else begin
      imem_rd_en  <= 1'b0;
      gpr_clr     <= 1'b0;
      issue_valid <= 1'b0;
      done        <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pc         <= entry_addr;
            imem_addr  <= entry_addr;
            imem_rd_en <= 1'b1;
            gpr_clr    <= 1'b1;
            in_slot    <= 1'b0;
            exit_pend  <= 1'b0;
            state      <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          issue_valid <= n_issue;
          issue_insn  <= imem_rdata;
          in_slot     <= n_slot;
          exit_pend   <= n_exit_pend;
          slot_tgt    <= n_tgt;
          if (n_finish) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            pc         <= n_pc;
            imem_addr  <= n_pc;
            imem_rd_en <= 1'b1;
            state      <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (!imem_rd_en && !issue_valid && !gpr_clr)); // R1
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    gpr_clr |=> !gpr_clr); // R2
  AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (imem_rd_en && gpr_clr && imem_addr == $past(entry_addr))); // R2
  AST_START_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    (start && imem_rd_en && !gpr_clr) |=> !gpr_clr); // R3
  AST_FETCH_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    imem_rd_en |=> !imem_rd_en); // R4
  AST_NO_BRANCH_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_insn[2:0] != 3'd7)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
endmodule

// File: tb/tb_msq_seq.sv
`timescale 1ns/1ps
module tb_msq_seq;
  localparam int PC_W  = 8;
  localparam int DEPTH = 1 << PC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PC_W-1:0] entry_addr = '0;
  logic imem_rd_en;
  logic [PC_W-1:0] imem_addr;
  logic [31:0] imem_rdata = '0;
  logic [2:0]  test_sel;
  logic [31:0] test_value;
  logic gpr_clr, issue_valid, busy, done;
  logic [31:0] issue_insn;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  logic [31:0] mem [DEPTH];
  logic [31:0] sregs [8];
  logic [31:0] exp_q [$];

  always #2.5 clk = ~clk;

  msq_seq #(.PC_W(PC_W)) dut (
    .clk(clk), .rst(rst), .start(start), .entry_addr(entry_addr),
    .imem_rd_en(imem_rd_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .test_sel(test_sel), .test_value(test_value), .gpr_clr(gpr_clr),
    .issue_valid(issue_valid), .issue_insn(issue_insn), .busy(busy), .done(done)
  );

  always @(posedge clk) if (imem_rd_en) imem_rdata <= mem[imem_addr];

  always @(posedge clk) begin
    if (gpr_clr) begin
      for (int i = 0; i < 8; i++) sregs[i] <= '0;
    end else if (issue_valid && issue_insn[10:8] != 3'd0) begin
      sregs[issue_insn[10:8]] <= {14'd0, issue_insn[31:14]};
    end
  end
  assign test_value = (test_sel == 3'd0) ? 32'd0 : sregs[test_sel];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] li(input int d, input int imm, input bit ex);
    logic [17:0] v = imm[17:0];
    logic [2:0]  r = d[2:0];
    return {v, 3'd0, r, ex, 4'd0, 3'd1};
  endfunction

  function automatic logic [31:0] br(input int a, input int off, input bit ne,
                                     input bit an, input bit ex);
    logic [17:0] v = off[17:0];
    logic [2:0]  r = a[2:0];
    return {v, r, 3'd0, ex, 1'b0, an, ne, 1'b0, 3'd7};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = li(7, 18'h3FFFF, 1'b0);
  endtask

  task automatic model(input int entry, output int n);
    int pc, pend, off;
    bit slot, exitp, isbr, taken;
    logic [31:0] w;
    logic [31:0] regs [8];
    for (int i = 0; i < 8; i++) regs[i] = '0;
    pc = entry; pend = 0; slot = 0; exitp = 0; n = 0;
    exp_q.delete();
    while (n < 500) begin
      w = mem[pc];
      n++;
      isbr = (w[2:0] == 3'd7);
      if (!isbr) begin
        exp_q.push_back(w);
        if (w[10:8] != 3'd0) regs[w[10:8]] = {14'd0, w[31:14]};
      end
      if (slot) begin
        if (exitp || w[7]) break;
        pc = pend; slot = 0;
      end else if (w[7]) begin
        exitp = 1; slot = 1; pc = (pc + 1) % DEPTH;
      end else if (isbr) begin
        off = $signed(w[31:14]);
        taken = w[4] ? (regs[w[13:11]] != 0) : (regs[w[13:11]] == 0);
        if (taken && w[5]) pc = (pc + off) & (DEPTH - 1);
        else if (taken) begin
          pend = (pc + off) & (DEPTH - 1); slot = 1; pc = (pc + 1) % DEPTH;
        end else pc = (pc + 1) % DEPTH;
      end else begin
        pc = (pc + 1) % DEPTH;
      end
    end
  endtask

  task automatic run(input int entry, input bit inject, input string req);
    int n;
    logic [31:0] e;
    model(entry, n);
    @(negedge clk);
    start = 1'b1; entry_addr = entry[PC_W-1:0];
    @(negedge clk);
    start = 1'b0;
    chk(gpr_clr && imem_rd_en && busy && imem_addr == entry[PC_W-1:0], "R2",
        "first fetch/clear", {24'd0, imem_addr}, entry);
    for (int k = 1; k <= 2 * n; k++) begin
      @(negedge clk);
      if (issue_valid) begin
        if (exp_q.size() == 0) chk(1'b0, req, "unexpected issue", issue_insn, 32'hx);
        else begin
          e = exp_q.pop_front();
          chk(issue_insn == e, req, "issue order", issue_insn, e);
        end
      end
      chk(done == (k == 2 * n), "R10", "done timing", {31'd0, done}, {31'd0, k == 2 * n});
      if (inject && k == 3) begin start = 1'b1; entry_addr = 8'h10; end
      if (inject && k == 4) start = 1'b0;
    end
    chk(exp_q.size() == 0, req, "words left unissued", exp_q.size(), 0);
    chk(!busy, "R10", "busy after done", {31'd0, busy}, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!issue_valid && !imem_rd_en && !done && !busy, "R3", "idle after call",
          {28'd0, issue_valid, imem_rd_en, done, busy}, 0);
    end
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !gpr_clr && !imem_rd_en && !issue_valid, "R1", "reset state",
        {27'd0, busy, done, gpr_clr, imem_rd_en, issue_valid}, 0);

    // R4 R10: straight line, exit then one trailing word
    clear_mem();
    mem[0] = li(1, 'h11, 0); mem[1] = li(2, 'h12, 0); mem[2] = li(3, 'h13, 1);
    mem[3] = li(4, 'h14, 0); mem[4] = li(5, 'h15, 0);
    run(0, 0, "R4");

    // R5 R6: zero-test, annulled taken branch
    clear_mem();
    mem['h10] = li(1, 'h21, 0); mem['h11] = br(0, 3, 0, 1, 0);
    mem['h12] = li(5, 'h22, 0); mem['h13] = li(5, 'h23, 0);
    mem['h14] = li(2, 'h24, 1); mem['h15] = li(3, 'h25, 0);
    run('h10, 0, "R6");

    // R5 R7: nonzero-test, taken branch with a delay slot
    clear_mem();
    mem['h20] = li(1, 5, 0); mem['h21] = br(1, 4, 1, 0, 0);
    mem['h22] = li(4, 'h32, 0); mem['h23] = li(4, 'h33, 0);
    mem['h25] = li(2, 'h35, 1); mem['h26] = li(3, 'h36, 0);
    run('h20, 0, "R7");

    // R8 R2: branches not taken; r2 left nonzero earlier must read as zero
    clear_mem();
    mem['h30] = li(1, 7, 0); mem['h31] = br(1, 5, 0, 1, 0);
    mem['h32] = li(4, 'h42, 0); mem['h33] = br(2, 5, 1, 0, 0);
    mem['h34] = li(4, 'h44, 1); mem['h35] = li(4, 'h45, 0);
    run('h30, 0, "R8");

    // R9: branch in a slot ignored; also a backward branch (R5)
    clear_mem();
    mem['h40] = br(0, 6, 0, 0, 0); mem['h41] = br(0, 2, 0, 1, 0);
    mem['h42] = li(4, 'h52, 1); mem['h43] = li(4, 'h53, 0);
    mem['h46] = li(4, 'h56, 0); mem['h47] = br(0, -5, 0, 1, 0);
    run('h40, 0, "R9");

    // R11: exit word inside a delay slot
    clear_mem();
    mem['h60] = br(0, 4, 0, 0, 0); mem['h61] = li(4, 'h61, 1);
    mem['h64] = li(4, 'h64, 0);
    run('h60, 0, "R11");

    // R10: exit flag on a branch word, branch part dropped
    clear_mem();
    mem['h70] = li(1, 1, 0); mem['h71] = br(1, 8, 1, 1, 1);
    mem['h72] = li(4, 'h72, 0); mem['h79] = li(4, 'h79, 0);
    run('h70, 0, "R10");

    // R12 R3: wrap past the top address, start pulse while busy
    clear_mem();
    mem['hFE] = li(4, 'h81, 0); mem['hFF] = li(4, 'h82, 0);
    mem['h00] = li(4, 'h83, 1); mem['h01] = li(4, 'h84, 0);
    mem['h10] = li(4, 'h99, 1);
    run('hFE, 1, "R12");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule